// File: doc/BRIEF.md
# Glitch-Free Clock Output Gating Controller

This block takes one running source clock and produces a set of gated copies of it. Each copy has its own enable bit in a small control register bank. The bank resets to a parameterised default pattern, so the outputs behave sensibly even if no configuration write ever arrives. An active-low halt input stops every output at once, and it overrides the individual enable bits.

After reset, a settle timer counts pulses on a tick input. Every output stays off until that count reaches a parameterised limit, which gives the oscillator time to stabilise (3 ms in silicon). A ready flag reports when the interval has expired.

Each output has its own gate register, clocked on the falling edge of the source clock. A gate can therefore open or close only while the source clock is low. As a result, a stopping output always finishes its current high phase at full width and then parks low. A restarting output always begins with a complete high phase.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: Once ready and not halted, each output `clk_o[i]` toggles with the source clock exactly when enable bit `i` of the register bank is 1, and is held at 0 when the bit is 0.
- R2: After reset, `ready_o` is 0 and every output is held at 0 until `SETTLE_TICKS` cycles with `tick_i`=1 have been counted at rising source-clock edges. `ready_o` rises right after the edge that counts the last of them. Further ticks change nothing, and `ready_o` stays 1 until the next reset.
- R3: While `halt_ni` is 0, every output is held at 0 whatever the enable bits hold.
- R4: A stopping output completes its last high phase at full width (one half source period) and then stays at 0. No high pulse on any output is ever shorter than a full source high phase.
- R5: An output that restarts, after halt is released or after its enable bit is set, begins with a complete high phase that starts on a rising source-clock edge.
- R6: On reset the enable bank holds `EN_DEFAULT`. A rising source-clock edge with `en_wr_i`=1 loads `en_val_i` into it. Bit `i` controls output `i`. Enable bits written while halted are kept and apply once halt is released.
- R7: Asserting `rst_ni` low forces all outputs to 0 and `ready_o` to 0 at once, restores `EN_DEFAULT`, and restarts the settle count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Running source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| halt_ni | input | 1 | Active-low halt; 0 stops every output |
| en_wr_i | input | 1 | Write strobe for the enable bank |
| en_val_i | input | N_OUT | Enable pattern loaded on a write |
| tick_i | input | 1 | Settle-timer tick, one source cycle wide |
| clk_o | output | N_OUT | Gated clock outputs |
| ready_o | output | 1 | Settle interval has expired |

## Verification
The bench builds the block with `N_OUT`=4, `SETTLE_TICKS`=5 and `EN_DEFAULT`=4'b1011. The short settle count lets every tick be walked one at a time, so the exact cycle in which ready rises can be checked, together with the ticks that arrive after it. Four outputs make it possible to sweep all sixteen enable patterns, once running and once halted. A pulse-width monitor on every output edge catches any shortened high phase across all halt, enable and release transitions.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  // counter width able to hold the value n
  function automatic int unsigned cnt_bits(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/clkgate_settle_timer.sv
module clkgate_settle_timer #(
  parameter int unsigned SETTLE_TICKS = 3000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned CW = clkgate_pkg::cnt_bits(SETTLE_TICKS);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_TICKS);

  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (tick_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
endmodule

// File: rtl/clkgate_en_bank.sv
module clkgate_en_bank #(
  parameter int unsigned N_OUT = 4,
  parameter logic [N_OUT-1:0] EN_DEFAULT = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [N_OUT-1:0] val_i,
  output logic [N_OUT-1:0] en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_o <= EN_DEFAULT;
    else if (wr_i) en_o <= val_i;
  end
endmodule

// File: rtl/clkgate_cell.sv
module clkgate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic gate_o,
  output logic clk_o
);
  // gate changes only while clk_i is low: no partial high phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_o <= 1'b0;
    else         gate_o <= run_i;
  end

  assign clk_o = clk_i & gate_o;
endmodule

// File: rtl/clkout_gate_ctrl.sv
module clkout_gate_ctrl #(
  parameter int unsigned N_OUT        = 4,
  parameter int unsigned SETTLE_TICKS = 3000,
  parameter logic [N_OUT-1:0] EN_DEFAULT = '1
) (
  input  logic             src_clk_i,
  input  logic             rst_ni,
  input  logic             halt_ni,
  input  logic             en_wr_i,
  input  logic [N_OUT-1:0] en_val_i,
  input  logic             tick_i,
  output logic [N_OUT-1:0] clk_o,
  output logic             ready_o
);
  logic [N_OUT-1:0] en_q;
  logic [N_OUT-1:0] run_w;
  logic [N_OUT-1:0] gate_w;

  clkgate_settle_timer #(.SETTLE_TICKS(SETTLE_TICKS)) u_timer (
    .clk_i (src_clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .done_o(ready_o)
  );

  clkgate_en_bank #(.N_OUT(N_OUT), .EN_DEFAULT(EN_DEFAULT)) u_bank (
    .clk_i (src_clk_i),
    .rst_ni(rst_ni),
    .wr_i  (en_wr_i),
    .val_i (en_val_i),
    .en_o  (en_q)
  );

  // halt and settle override every enable bit
  assign run_w = (ready_o && halt_ni) ? en_q : '0;

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    clkgate_cell u_cell (
      .clk_i (src_clk_i),
      .rst_ni(rst_ni),
      .run_i (run_w[g]),
      .gate_o(gate_w[g]),
      .clk_o (clk_o[g])
    );
  end

  p_en_follow_r1: assert property (@(negedge src_clk_i) disable iff (!rst_ni)
    (ready_o && halt_ni) |=> (gate_w == $past(en_q)));

  p_halt_stop_r3: assert property (@(negedge src_clk_i) disable iff (!rst_ni)
    !halt_ni |=> (gate_w == '0));

  p_settle_hold_r2: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    !ready_o |-> (gate_w == '0));

  p_ready_sticky_r2: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
endmodule

// File: tb/clkout_gate_ctrl_tb.sv
`timescale 1ns/1ps
module clkout_gate_ctrl_tb;
  localparam int unsigned N = 4;
  localparam int unsigned ST = 5;
  localparam logic [N-1:0] DEF = 4'b1011;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic halt_ni = 1'b1;
  logic en_wr = 1'b0;
  logic [N-1:0] en_val = '0;
  logic tick = 1'b0;
  logic [N-1:0] clk_o;
  logic ready;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  clkout_gate_ctrl #(.N_OUT(N), .SETTLE_TICKS(ST), .EN_DEFAULT(DEF)) u_dut (
    .src_clk_i(clk), .rst_ni(rst_ni), .halt_ni(halt_ni), .en_wr_i(en_wr),
    .en_val_i(en_val), .tick_i(tick), .clk_o(clk_o), .ready_o(ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // pulse-width monitor: every high pulse must be a full half period (R4, R5)
  realtime rise_t [N];
  logic [N-1:0] prev_o = '0;
  always @(clk_o) begin
    for (int i = 0; i < N; i++) begin
      if (clk_o[i] && !prev_o[i]) rise_t[i] = $realtime;
      else if (!clk_o[i] && prev_o[i] && rst_ni)
        chk(($realtime - rise_t[i]) > 1.999 && ($realtime - rise_t[i]) < 2.001,
            "R4/R5 pulse width ps", int'(($realtime - rise_t[i]) * 1000), 2000);
    end
    prev_o = clk_o;
  end

  // sample a high phase (expect pattern) and the following low phase (expect 0)
  task automatic expect_out(input logic [N-1:0] exp, input string req);
    repeat (2) @(posedge clk);
    @(posedge clk); #1;
    chk(clk_o == exp, req, clk_o, exp);
    @(negedge clk); #1;
    chk(clk_o == '0, {req, " low phase"}, clk_o, 0);
  endtask

  task automatic wr_en(input logic [N-1:0] v);
    @(negedge clk); #1;
    en_val = v; en_wr = 1'b1;
    @(negedge clk); #1;
    en_wr = 1'b0;
  endtask

  task automatic one_tick();
    @(negedge clk); #1; tick = 1'b1;
    @(negedge clk); #1; tick = 1'b0;
  endtask

  task automatic set_halt(input logic v);
    @(posedge clk); #1; halt_ni = v;
  endtask

  initial begin
    #(200000 * 4);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #7; rst_ni = 1'b1;
    // R7 / R2: reset state
    #1;
    chk(ready == 1'b0, "R2 ready after reset", ready, 0);
    expect_out('0, "R2 outputs held before settle");

    // R2: walk the settle count tick by tick
    for (int k = 1; k <= ST; k++) begin
      one_tick();
      chk(ready == (k == ST), "R2 ready after tick", ready, (k == ST));
      if (k < ST) expect_out('0, "R2 held during settle");
    end
    // R6: default enables apply once ready
    expect_out(DEF, "R6 default enable pattern");
    // R2: extra ticks have no effect
    repeat (3) one_tick();
    chk(ready == 1'b1, "R2 ready stays after extra ticks", ready, 1);
    expect_out(DEF, "R2 outputs unchanged after extra ticks");

    // R1 / R6: sweep every enable pattern while running
    for (int v = 0; v < 16; v++) begin
      wr_en(N'(v));
      expect_out(N'(v), "R1 enable sweep");
    end

    // R3: halt overrides every pattern; R6 writes while halted are kept
    wr_en(4'b1111);
    set_halt(1'b0);
    expect_out('0, "R3 halt stops all");
    for (int v = 0; v < 16; v++) begin
      wr_en(N'(v));
      expect_out('0, "R3 halt priority over enables");
    end
    wr_en(4'b0110);
    set_halt(1'b1);
    expect_out(4'b0110, "R5/R6 restart with enables written in halt");

    // R4/R5: repeated halt toggling mid-run, widths checked by monitor
    for (int k = 0; k < 6; k++) begin
      set_halt(k[0]);
      repeat (k + 1) @(posedge clk);
    end
    set_halt(1'b1);
    expect_out(4'b0110, "R4 outputs resume after toggling");

    // R7: reset mid-run, applied during a low phase
    @(negedge clk); #0.5;
    rst_ni = 1'b0;
    #0.5;
    chk(ready == 1'b0, "R7 ready cleared by reset", ready, 0);
    chk(clk_o == '0, "R7 outputs cleared by reset", clk_o, 0);
    @(negedge clk); #1;
    rst_ni = 1'b1;
    expect_out('0, "R7 outputs held after reset");
    for (int k = 1; k <= ST; k++) one_tick();
    chk(ready == 1'b1, "R7 settle restarted from zero", ready, 1);
    expect_out(DEF, "R7 default enables restored");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule